// File: doc/BRIEF.md
# Single-Cycle RISC Core

This block is a 32-bit processor core that retires one instruction on every clock edge. It fetches a word from an internal instruction array at the program counter, decodes it, reads two operands from a 32-entry register file, runs them through an ALU, and commits the result at the next edge. The result goes into the register file or the data array, or it becomes a new program counter. The instruction subset covers five register-register operations (add, sub, and, or, signed set-less-than), word load, word store and branch-if-equal.

Decoding happens in two levels. The opcode alone produces the datapath control lines and a 2-bit operation class. That class, together with the 6-bit function field, selects one of five ALU functions. A branch is taken only when the branch control line and the ALU zero flag are both high.

Both memories are word-addressed arrays inside the block. A preload port fills them while the core is held in reset, and that port is the only way to put values into them. The core drives its write-back and store activity onto observation ports so that the surrounding logic can follow execution.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0. While `rst` is high, `wb_en` and `st_en` are 0.
- R2: For an instruction that is not a taken branch, the next PC is PC+4. Fetch always reads instruction word PC[9:2].
- R3: Opcode 0 (bits 31:26) is the register-register format. It reads rs (bits 25:21) and rt (bits 20:16) and writes rd (bits 15:11). Function field (bits 5:0) 32 adds, 34 subtracts rt from rs, 36 performs bitwise and, and 37 performs bitwise or.
- R4: Function code 42 writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R5: Opcode 35 loads the data word at index (rs + sign-extended bits 15:0)[9:2] into rt.
- R6: Opcode 43 writes rt to the data word at index (rs + sign-extended bits 15:0)[9:2] and writes no register.
- R7: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4+(sign-extended offset << 2). Otherwise the next PC is PC+4, and no register or memory is written.
- R8: Register 0 reads as zero. A write aimed at it is dropped, and `wb_en` stays 0 for it.
- R9: An instruction that reads and writes the same register sees that register's value from before the instruction.
- R10: With `ld_en` high, `ld_data` is written at word `ld_addr` into the instruction array when `ld_sel` is 0, or into the data array when `ld_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write strobe |
| ld_sel | input | 1 | Preload target: 0 instruction array, 1 data array |
| ld_addr | input | 8 | Preload word index |
| ld_data | input | 32 | Preload word |
| pc | output | 32 | Address of the instruction now executing |
| wb_en | output | 1 | This instruction writes a nonzero register at the coming edge |
| wb_idx | output | 5 | Destination register of that write |
| wb_val | output | 32 | Value to be written |
| st_en | output | 1 | This instruction stores to the data array at the coming edge |
| st_idx | output | 8 | Data word index of that store |
| st_val | output | 32 | Value to be stored |

## Verification
Reading a register and writing it fall in the same cycle. The bench provokes this with an add whose source and destination are the same register, and expects the doubled old value. A load placed right after a store to the same word checks that the stored value has already landed in the data array. The branch decision and the PC update also share one cycle. The bench judges this through the PC sequence, using one untaken branch, one forward taken branch that skips three words, and a backward branch that targets itself.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int MEM_AW = 8;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;
    localparam logic [5:0] OP_BEQ   = 6'd4;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FUNC = 2'b10
    } op_class_e;

    typedef enum logic [2:0] {
        FU_ADD, FU_SUB, FU_AND, FU_OR, FU_SLT
    } alu_fn_e;

    typedef struct packed {
        logic      dst_rd;
        logic      src_imm;
        logic      wb_mem;
        logic      reg_we;
        logic      mem_re;
        logic      mem_we;
        logic      is_branch;
        op_class_e cls;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_fn_e    fn
);
    always_comb begin
        ctl = '0;
        ctl.cls = CLS_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctl.dst_rd = 1'b1;
                ctl.reg_we = 1'b1;
                ctl.cls    = CLS_FUNC;
            end
            OP_LOAD: begin
                ctl.src_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.mem_re  = 1'b1;
            end
            OP_STORE: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.cls       = CLS_SUB;
            end
            default: ;
        endcase
    end

    always_comb begin
        fn = FU_ADD;
        case (ctl.cls)
            CLS_SUB:  fn = FU_SUB;
            CLS_FUNC: begin
                case (funct)
                    FN_SUB:  fn = FU_SUB;
                    FN_AND:  fn = FU_AND;
                    FN_OR:   fn = FU_OR;
                    FN_SLT:  fn = FU_SLT;
                    default: fn = FU_ADD;
                endcase
            end
            default:  fn = FU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        case (fn)
            FU_SUB:  y = a - b;
            FU_AND:  y = a & b;
            FU_OR:   y = a | b;
            FU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [XLEN-1:0]   wd,
    input  logic [RIDX_W-1:0] ra0,
    input  logic [RIDX_W-1:0] ra1,
    output logic [XLEN-1:0]   rd0,
    output logic [XLEN-1:0]   rd1
);
    logic [XLEN-1:0] regs [1:NREG-1];

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (we && wa == RIDX_W'(g)) regs[g] <= wd;
        end
    end

    assign rd0 = (ra0 == '0) ? '0 : regs[ra0];
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   pc,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_val,
    output logic              st_en,
    output logic [MEM_AW-1:0] st_idx,
    output logic [XLEN-1:0]   st_val
);
    localparam int MEM_WORDS = 1 << MEM_AW;

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0]   pc_q, pc_plus4, br_tgt, instr, imm_x;
    logic [XLEN-1:0]   opa, opb_reg, opb, alu_y, ld_word;
    logic [RIDX_W-1:0] rs, rt, rd, dst;
    logic              zero, take, rf_we;
    ctrl_t             ctl;
    alu_fn_e           fn;

    assign instr    = imem[pc_q[MEM_AW+1:2]];
    assign rs       = instr[25:21];
    assign rt       = instr[20:16];
    assign rd       = instr[15:11];
    assign imm_x    = sext16(instr[15:0]);
    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + (imm_x << 2);

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl),
        .fn     (fn)
    );

    sc_regfile u_rf (
        .clk (clk),
        .we  (rf_we),
        .wa  (dst),
        .wd  (wb_val),
        .ra0 (rs),
        .ra1 (rt),
        .rd0 (opa),
        .rd1 (opb_reg)
    );

    assign opb = ctl.src_imm ? imm_x : opb_reg;

    sc_alu u_alu (
        .a    (opa),
        .b    (opb),
        .fn   (fn),
        .y    (alu_y),
        .zero (zero)
    );

    assign take    = ctl.is_branch & zero;
    assign ld_word = dmem[alu_y[MEM_AW+1:2]];
    assign dst     = ctl.dst_rd ? rd : rt;
    assign wb_val  = ctl.wb_mem ? ld_word : alu_y;
    assign rf_we   = ctl.reg_we & ~rst;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= take ? br_tgt : pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_sel) imem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_sel)   dmem[ld_addr] <= ld_data;
        else if (st_en)        dmem[st_idx]  <= st_val;
    end

    assign pc     = pc_q;
    assign wb_en  = rf_we & (dst != '0);
    assign wb_idx = dst;
    assign st_en  = ctl.mem_we & ~rst;
    assign st_idx = alu_y[MEM_AW+1:2];
    assign st_val = opb_reg;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic              take,
    input logic [XLEN-1:0]   tgt,
    input logic              wb_en,
    input logic [RIDX_W-1:0] wb_idx,
    input logic              st_en,
    input logic              mem_re
);
    assert_pc_reset_R1: assert property (@(posedge clk) rst |=> pc == '0);

    assert_quiet_reset_R1: assert property (@(posedge clk) rst |-> (!wb_en && !st_en));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !take |=> pc == $past(pc) + 32'd4);

    assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
        take |=> pc == $past(tgt));

    assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wb_idx != '0);

    assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
        st_en |-> (!wb_en && !mem_re));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc_q),
    .take   (take),
    .tgt    (br_tgt),
    .wb_en  (wb_en),
    .wb_idx (wb_idx),
    .st_en  (st_en),
    .mem_re (ctl.mem_re)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
    import sc_core_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_en = 1'b0;
    logic              ld_sel = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [XLEN-1:0]   ld_data = '0;
    logic [XLEN-1:0]   pc;
    logic              wb_en, st_en;
    logic [RIDX_W-1:0] wb_idx;
    logic [XLEN-1:0]   wb_val, st_val;
    logic [MEM_AW-1:0] st_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] pc_q   [$];
    logic [36:0] wb_q   [$];
    logic [39:0] st_q   [$];

    always #2.5 clk = ~clk;

    sc_core u_sc_core (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
        .st_en(st_en), .st_idx(st_idx), .st_val(st_val)
    );

    function automatic logic [31:0] rty(input int s, input int t, input int d, input logic [5:0] f);
        return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, f};
    endfunction

    function automatic logic [31:0] ity(input logic [5:0] op, input int s, input int t, input int imm);
        return {op, 5'(s), 5'(t), 16'(imm)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input bit sel, input int idx, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = MEM_AW'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic push_wb(input int r, input logic [31:0] v);
        wb_q.push_back({5'(r), v});
    endtask

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: preload both arrays through the load port
        load(1, 0, 32'd5);
        load(1, 1, 32'hFFFF_FFFD);
        load(0, 0,  ity(OP_LOAD, 0, 1, 0));
        load(0, 1,  ity(OP_LOAD, 0, 2, 4));
        load(0, 2,  rty(1, 2, 3, FN_ADD));
        load(0, 3,  rty(1, 2, 4, FN_SUB));
        load(0, 4,  rty(1, 2, 5, FN_AND));
        load(0, 5,  rty(1, 2, 6, FN_OR));
        load(0, 6,  rty(2, 1, 7, FN_SLT));
        load(0, 7,  rty(1, 2, 8, FN_SLT));
        load(0, 8,  rty(1, 1, 0, FN_ADD));
        load(0, 9,  rty(0, 0, 9, FN_ADD));
        load(0, 10, ity(OP_STORE, 0, 4, 16));
        load(0, 11, ity(OP_LOAD, 0, 10, 16));
        load(0, 12, ity(OP_BEQ, 1, 2, 5));
        load(0, 13, ity(OP_BEQ, 3, 3, 3));
        load(0, 14, rty(1, 1, 11, FN_ADD));
        load(0, 15, rty(1, 1, 11, FN_ADD));
        load(0, 16, rty(1, 1, 11, FN_ADD));
        load(0, 17, rty(1, 1, 12, FN_ADD));
        load(0, 18, rty(1, 1, 1, FN_ADD));
        load(0, 19, ity(OP_LOAD, 10, 13, -4));
        load(0, 20, ity(OP_BEQ, 0, 0, -1));

        // driver: expected scoreboard items
        for (int i = 0; i <= 13; i++) pc_q.push_back(32'(4 * i));
        for (int i = 17; i <= 20; i++) pc_q.push_back(32'(4 * i));
        for (int i = 0; i < 4; i++) pc_q.push_back(32'd80);
        push_wb(1, 32'd5);           // R5
        push_wb(2, 32'hFFFF_FFFD);   // R5
        push_wb(3, 32'd2);           // R3 add
        push_wb(4, 32'd8);           // R3 sub
        push_wb(5, 32'd5);           // R3 and
        push_wb(6, 32'hFFFF_FFFD);   // R3 or
        push_wb(7, 32'd1);           // R4
        push_wb(8, 32'd0);           // R4
        push_wb(9, 32'd0);           // R8 reads zero
        push_wb(10, 32'd8);          // R5 after R6 store
        push_wb(12, 32'd10);         // R7 target reached
        push_wb(1, 32'd10);          // R9
        push_wb(13, 32'hFFFF_FFFD);  // R5 negative offset
        st_q.push_back({8'd4, 32'd8}); // R6

        @(negedge clk); #1;
        check(pc == 0, "R1 pc", 64'(pc), 64'd0);
        check(!wb_en && !st_en, "R1 quiet", {wb_en, st_en}, 0);
        @(negedge clk);
        rst = 1'b0;

        // monitor
        while (pc_q.size() > 0) begin
            #1;
            begin
                logic [31:0] ep;
                ep = pc_q.pop_front();
                check(pc == ep, "R2/R7 pc", 64'(pc), 64'(ep));
            end
            if (wb_en) begin
                if (wb_q.size() == 0)
                    check(0, "R7/R8 extra write", {wb_idx, wb_val}, 0);
                else begin
                    logic [36:0] ew;
                    ew = wb_q.pop_front();
                    check({wb_idx, wb_val} == ew, "R3/R4/R5/R8/R9 writeback", {wb_idx, wb_val}, ew);
                end
            end
            if (st_en) begin
                if (st_q.size() == 0)
                    check(0, "R6 extra store", {st_idx, st_val}, 0);
                else begin
                    logic [39:0] es;
                    es = st_q.pop_front();
                    check({st_idx, st_val} == es, "R6 store", {st_idx, st_val}, es);
                end
            end
            @(negedge clk);
        end
        check(wb_q.size() == 0, "R3 missing writes", 64'(wb_q.size()), 0);
        check(st_q.size() == 0, "R6 missing stores", 64'(st_q.size()), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule